// File: doc/BRIEF.md
# Bidirectional Fault-Calculus Gate Cell

This block is one primitive logic gate (AND, OR, NAND, NOR or inverter, picked by a parameter) built for path-sensitization test generation. It does not carry plain bits. It carries a small alphabet of line codes: ordinary 0 and 1, the don't-care X, the two fault symbols D (good 1, faulty 0) and DBAR (good 0, faulty 1), and an undefined U. A netlist of such cells is driven by an outer sequencer. The sequencer places a fault symbol on a line and lets it ripple toward the outputs. It then asks each cell to work backwards and choose input values that justify a required output.

Each port comes as a pair of separate code buses: the code arriving at the cell and the code the cell drives. There is no tri-state wiring. In propagate mode the cell evaluates its output from the arriving input codes, treating the good and faulty halves separately. In justify mode it takes a required output code and writes codes back onto the inputs that propagation left undecided. It keeps the inputs that propagation fixed. A neighbouring resolver may later report a majority conflict on one of those inputs. The cell first tries the swapped controlling assignment, then insists on its value, and finally flips its own output so that the conflict moves downstream. A strong-U code on any port clears the cell.

Top module: `dcg_cell`

## Requirements
- R1: While reset is asserted, and after its release until the first mode action, `out_o`, `in_a_o` and `in_b_o` all read U (code 5).
- R2: Code encoding is 0=0, 1=1, 2=X, 3=D, 4=DBAR, 5=U, 6=SU, 7=CM0, 8=CM1, 9=IO0, 10=IO1, 11=NPD, 12=NPDBAR. With `mode_i`=1 (propagate), the edge after the inputs are applied sets `out_o` to the gate function applied separately to the good and faulty halves of the input codes. A result with both halves known becomes 0, 1, D or DBAR; for example, AND(D,DBAR) is 0 and NOR(D,0) is DBAR.
- R3: In propagate mode, a result with an unknown half reads X when no input is U. It reads U when an input is U. For an AND, (1,X) gives X, (U,1) gives U and (0,U) gives 0.
- R4: With `mode_i`=2 (justify) and a new required code on `out_req_i` (0, 1, D or DBAR), the cell drives that code on `out_o`. It drives the gate's non-controlling value on every input that propagation left X or U, and it drives the propagated code back on every other input. An AND that holds D on input A and is asked for D drives 1 on B.
- R5: When the required output is the gate's controlling outcome and neither input is fixed, the first choice is the controlling value on A and X on B. If one input is fixed at the controlling value, the undecided input gets X. If one input is fixed non-controlling, the other gets the controlling value.
- R6: In justify mode, a CM0 (7) or CM1 (8) arriving on an input whose driven value equals that majority causes no change on any output. Input A is examined before input B.
- R7: An opposing majority on an input, when the first-choice controlling pair is in use and no retry has been made, swaps the pair (for example A=0,B=X becomes A=X,B=0). The output is kept.
- R8: An opposing majority with no alternative available, and no retry yet, makes the cell drive IO0 (9) or IO1 (10) on that input, matching its held value.
- R9: An opposing majority that arrives after a swap or an insist has already been made flips `out_o` to the complementary code (0 and 1 exchange). This happens once per request; later conflicts are ignored.
- R10: An NPD (11) or NPDBAR (12) code on an input in propagate mode leaves all three outputs unchanged.
- R11: An SU code (6) on `in_a_i`, `in_b_i` or `out_req_i` forces all three outputs to U on the next edge, in any mode, and discards the pending request.
- R12: Each new justification request clears the retry and insist history. A request counts as new when the code differs from the last one, or when the cell has left justify mode since it was given. After the new request, a later opposing majority is again answered by a swap.
- R13: With the inverter variant only input A is used. It propagates the complement (D becomes DBAR), and `in_b_o` stays U.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 1 = propagate, 2 = justify, other values hold |
| in_a_i | input | 4 | Code arriving on input A (value, conflict, NPD or SU) |
| in_b_i | input | 4 | Code arriving on input B |
| out_req_i | input | 4 | Code arriving on the output side (required value or SU) |
| in_a_o | output | 4 | Code the cell drives back onto input A |
| in_b_o | output | 4 | Code the cell drives back onto input B |
| out_o | output | 4 | Code the cell drives on its output |

## Verification
Every piece of state sits one register away from a port. A wrong fixed value from propagation appears on the matching input-return bus in the cycle after the propagate step. If the retry flag fails to clear, the conflict answer one cycle after the next conflict is wrong: a flip or an insist code appears where the swapped pair was expected. A wrongly kept or lost request shows up as an input assignment that is missing or repeated, one edge after the request code is applied. The bench orders its scenarios so that each history flag is set and then exercised by a later conflict cycle.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

   localparam int CODE_W = 4;
   localparam int MODE_W = 2;

   typedef enum logic [CODE_W-1:0] {
      C_ZERO = 4'd0,
      C_ONE  = 4'd1,
      C_X    = 4'd2,
      C_D    = 4'd3,
      C_DB   = 4'd4,
      C_U    = 4'd5,
      C_SU   = 4'd6,
      C_CM0  = 4'd7,
      C_CM1  = 4'd8,
      C_IO0  = 4'd9,
      C_IO1  = 4'd10,
      C_NPD  = 4'd11,
      C_NPDB = 4'd12
   } code_e;

   typedef enum logic [2:0] {
      G_AND, G_OR, G_NAND, G_NOR, G_NOT
   } gate_e;

   localparam logic [MODE_W-1:0] M_PROP = 2'd1;
   localparam logic [MODE_W-1:0] M_JUST = 2'd2;

   typedef enum logic [2:0] {
      A_NONE, A_SWAP, A_INS_A, A_INS_B, A_FLIP
   } act_e;

   // ternary half-value: 0, 1 or unknown
   localparam logic [1:0] T0 = 2'd0;
   localparam logic [1:0] T1 = 2'd1;
   localparam logic [1:0] TU = 2'd2;

   function automatic logic [1:0] good_of(code_e c);
      case (c)
         C_ZERO, C_DB: return T0;
         C_ONE,  C_D:  return T1;
         default:      return TU;
      endcase
   endfunction

   function automatic logic [1:0] bad_of(code_e c);
      case (c)
         C_ZERO, C_D:  return T0;
         C_ONE,  C_DB: return T1;
         default:      return TU;
      endcase
   endfunction

   function automatic logic [1:0] t_and(logic [1:0] a, logic [1:0] b);
      if (a == T0 || b == T0) return T0;
      if (a == T1 && b == T1) return T1;
      return TU;
   endfunction

   function automatic logic [1:0] t_or(logic [1:0] a, logic [1:0] b);
      if (a == T1 || b == T1) return T1;
      if (a == T0 && b == T0) return T0;
      return TU;
   endfunction

   function automatic logic [1:0] t_inv(logic [1:0] a);
      if (a == T0) return T1;
      if (a == T1) return T0;
      return TU;
   endfunction

   function automatic code_e t_join(logic [1:0] g, logic [1:0] f, logic any_u);
      if (g != TU && f != TU) begin
         case ({g[0], f[0]})
            2'b00:   return C_ZERO;
            2'b11:   return C_ONE;
            2'b10:   return C_D;
            default: return C_DB;
         endcase
      end
      return any_u ? C_U : C_X;
   endfunction

   function automatic code_e code_not(code_e c);
      case (c)
         C_ZERO:  return C_ONE;
         C_ONE:   return C_ZERO;
         C_D:     return C_DB;
         C_DB:    return C_D;
         default: return c;
      endcase
   endfunction

   function automatic logic is_value(code_e c);
      return (c == C_ZERO) || (c == C_ONE) || (c == C_D) || (c == C_DB);
   endfunction

   function automatic logic is_open(code_e c);
      return (c == C_X) || (c == C_U);
   endfunction

   function automatic logic is_cm(code_e c);
      return (c == C_CM0) || (c == C_CM1);
   endfunction

   function automatic logic is_npd(code_e c);
      return (c == C_NPD) || (c == C_NPDB);
   endfunction

endpackage

// File: rtl/dcg_fwd_eval.sv
module dcg_fwd_eval
   import dcg_pkg::*;
#(
   parameter gate_e GATE = G_AND
) (
   input  code_e a_i,
   input  code_e b_i,
   output code_e y_o
);
   localparam bit IS_INV = (GATE == G_NAND) || (GATE == G_NOR) || (GATE == G_NOT);
   localparam bit IS_OR  = (GATE == G_OR) || (GATE == G_NOR);

   generate
      if (GATE == G_NOT) begin : g_single
         always_comb y_o = t_join(t_inv(good_of(a_i)), t_inv(bad_of(a_i)), a_i == C_U);
      end else begin : g_dual
         logic [1:0] g_base, f_base, g_out, f_out;
         always_comb begin
            g_base = IS_OR ? t_or(good_of(a_i), good_of(b_i))
                           : t_and(good_of(a_i), good_of(b_i));
            f_base = IS_OR ? t_or(bad_of(a_i), bad_of(b_i))
                           : t_and(bad_of(a_i), bad_of(b_i));
            g_out  = IS_INV ? t_inv(g_base) : g_base;
            f_out  = IS_INV ? t_inv(f_base) : f_base;
            y_o    = t_join(g_out, f_out, (a_i == C_U) || (b_i == C_U));
         end
      end
   endgenerate
endmodule

// File: rtl/dcg_just_plan.sv
module dcg_just_plan
   import dcg_pkg::*;
#(
   parameter gate_e GATE = G_AND
) (
   input  code_e req_i,
   input  code_e fix_a_i,
   input  code_e fix_b_i,
   output code_e plan_a_o,
   output code_e plan_b_o,
   output logic  alt_ok_o
);
   localparam bit    IS_INV = (GATE == G_NAND) || (GATE == G_NOR) || (GATE == G_NOT);
   localparam bit    IS_OR  = (GATE == G_OR) || (GATE == G_NOR);
   localparam code_e CTL    = IS_OR ? C_ONE : C_ZERO;
   localparam code_e NCTL   = IS_OR ? C_ZERO : C_ONE;

   code_e base_req;
   always_comb base_req = IS_INV ? code_not(req_i) : req_i;

   generate
      if (GATE == G_NOT) begin : g_single
         always_comb begin
            plan_a_o = is_open(fix_a_i) ? base_req : fix_a_i;
            plan_b_o = C_U;
            alt_ok_o = 1'b0;
         end
      end else begin : g_dual
         logic open_a, open_b;
         always_comb begin
            open_a   = is_open(fix_a_i);
            open_b   = is_open(fix_b_i);
            alt_ok_o = 1'b0;
            if (base_req == CTL) begin
               if (fix_a_i == CTL || fix_b_i == CTL) begin
                  plan_a_o = open_a ? C_X : fix_a_i;
                  plan_b_o = open_b ? C_X : fix_b_i;
               end else if (open_a && open_b) begin
                  plan_a_o = CTL;
                  plan_b_o = C_X;
                  alt_ok_o = 1'b1;
               end else begin
                  plan_a_o = open_a ? CTL : fix_a_i;
                  plan_b_o = open_b ? CTL : fix_b_i;
               end
            end else begin
               plan_a_o = open_a ? NCTL : fix_a_i;
               plan_b_o = open_b ? NCTL : fix_b_i;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dcg_conflict.sv
module dcg_conflict
   import dcg_pkg::*;
(
   input  code_e cin_a_i,
   input  code_e cin_b_i,
   input  code_e asg_a_i,
   input  code_e asg_b_i,
   input  logic  alt_ok_i,
   input  logic  tried_i,
   input  logic  pushed_i,
   output act_e  act_o
);
   logic  sel_b, hit, maj_one, opposed;
   code_e held;

   always_comb begin
      sel_b   = !is_cm(cin_a_i);
      hit     = is_cm(cin_a_i) || is_cm(cin_b_i);
      maj_one = sel_b ? (cin_b_i == C_CM1) : (cin_a_i == C_CM1);
      held    = sel_b ? asg_b_i : asg_a_i;
      opposed = hit && ((held == C_ZERO && maj_one) || (held == C_ONE && !maj_one));
      if (!opposed || pushed_i)  act_o = A_NONE;
      else if (!tried_i && alt_ok_i) act_o = A_SWAP;
      else if (!tried_i)         act_o = sel_b ? A_INS_B : A_INS_A;
      else                       act_o = A_FLIP;
   end
endmodule

// File: rtl/dcg_cell.sv
module dcg_cell
   import dcg_pkg::*;
#(
   parameter gate_e GATE = G_AND
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [MODE_W-1:0]   mode_i,
   input  logic [CODE_W-1:0]   in_a_i,
   input  logic [CODE_W-1:0]   in_b_i,
   input  logic [CODE_W-1:0]   out_req_i,
   output logic [CODE_W-1:0]   in_a_o,
   output logic [CODE_W-1:0]   in_b_o,
   output logic [CODE_W-1:0]   out_o
);
   localparam bit DUAL = (GATE != G_NOT);

   if ($bits(code_e) != CODE_W) begin : g_width_chk
      $error("code enum width must equal CODE_W");
   end

   code_e ca, cb, creq;
   always_comb begin
      ca   = code_e'(in_a_i);
      cb   = code_e'(in_b_i);
      creq = code_e'(out_req_i);
   end

   // state
   code_e fix_a_q, fix_b_q, asg_a_q, asg_b_q, out_q, req_q;
   logic  ins_a_q, ins_b_q, alt_q, tried_q, pushed_q, req_vld;

   // submodule results
   code_e fwd_y, plan_a, plan_b;
   logic  plan_alt;
   act_e  act;

   dcg_fwd_eval #(.GATE(GATE)) fwd_i (
      .a_i(ca), .b_i(cb), .y_o(fwd_y)
   );

   dcg_just_plan #(.GATE(GATE)) plan_i (
      .req_i(creq), .fix_a_i(fix_a_q), .fix_b_i(fix_b_q),
      .plan_a_o(plan_a), .plan_b_o(plan_b), .alt_ok_o(plan_alt)
   );

   dcg_conflict conf_i (
      .cin_a_i(ca), .cin_b_i(DUAL ? cb : C_X),
      .asg_a_i(asg_a_q), .asg_b_i(asg_b_q),
      .alt_ok_i(alt_q), .tried_i(tried_q), .pushed_i(pushed_q),
      .act_o(act)
   );

   logic any_su, npd_in, new_req;
   always_comb begin
      any_su  = (ca == C_SU) || (cb == C_SU) || (creq == C_SU);
      npd_in  = is_npd(ca) || (DUAL && is_npd(cb));
      new_req = is_value(creq) && (!req_vld || creq != req_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fix_a_q  <= C_U;
         fix_b_q  <= C_U;
         asg_a_q  <= C_U;
         asg_b_q  <= C_U;
         out_q    <= C_U;
         req_q    <= C_U;
         ins_a_q  <= 1'b0;
         ins_b_q  <= 1'b0;
         alt_q    <= 1'b0;
         tried_q  <= 1'b0;
         pushed_q <= 1'b0;
         req_vld  <= 1'b0;
      end else if (any_su) begin
         fix_a_q  <= C_U;
         fix_b_q  <= C_U;
         asg_a_q  <= C_U;
         asg_b_q  <= C_U;
         out_q    <= C_U;
         ins_a_q  <= 1'b0;
         ins_b_q  <= 1'b0;
         alt_q    <= 1'b0;
         tried_q  <= 1'b0;
         pushed_q <= 1'b0;
         req_vld  <= 1'b0;
      end else if (mode_i == M_PROP) begin
         req_vld <= 1'b0;
         if (!npd_in) begin
            if (ca <= C_U) begin
               fix_a_q <= ca;
               asg_a_q <= ca;
            end
            if (DUAL && cb <= C_U) begin
               fix_b_q <= cb;
               asg_b_q <= cb;
            end
            out_q    <= fwd_y;
            ins_a_q  <= 1'b0;
            ins_b_q  <= 1'b0;
            alt_q    <= 1'b0;
            tried_q  <= 1'b0;
            pushed_q <= 1'b0;
         end
      end else if (mode_i == M_JUST) begin
         if (new_req) begin
            asg_a_q  <= plan_a;
            asg_b_q  <= plan_b;
            out_q    <= creq;
            req_q    <= creq;
            req_vld  <= 1'b1;
            alt_q    <= plan_alt;
            ins_a_q  <= 1'b0;
            ins_b_q  <= 1'b0;
            tried_q  <= 1'b0;
            pushed_q <= 1'b0;
         end else if (req_vld) begin
            case (act)
               A_SWAP: begin
                  asg_a_q <= asg_b_q;
                  asg_b_q <= asg_a_q;
                  tried_q <= 1'b1;
               end
               A_INS_A: begin
                  ins_a_q <= 1'b1;
                  tried_q <= 1'b1;
               end
               A_INS_B: begin
                  ins_b_q <= 1'b1;
                  tried_q <= 1'b1;
               end
               A_FLIP: begin
                  out_q    <= code_not(out_q);
                  pushed_q <= 1'b1;
               end
               default: ;
            endcase
         end
      end else begin
         req_vld <= 1'b0;
      end
   end

   always_comb begin
      in_a_o = ins_a_q ? ((asg_a_q == C_ONE) ? C_IO1 : C_IO0) : asg_a_q;
      in_b_o = ins_b_q ? ((asg_b_q == C_ONE) ? C_IO1 : C_IO0) : asg_b_q;
      out_o  = out_q;
   end
endmodule

// File: rtl/dcg_cell_chk.sv
module dcg_cell_chk
   import dcg_pkg::*;
#(
   parameter gate_e GATE = G_AND
) (
   input logic                clk,
   input logic                rst_n,
   input logic [MODE_W-1:0]   mode_i,
   input logic [CODE_W-1:0]   in_a_i,
   input logic [CODE_W-1:0]   in_b_i,
   input logic [CODE_W-1:0]   out_req_i,
   input logic [CODE_W-1:0]   in_a_o,
   input logic [CODE_W-1:0]   in_b_o,
   input logic [CODE_W-1:0]   out_o,
   input logic                new_req,
   input logic                req_vld,
   input logic                pushed_q
);
   localparam bit DUAL = (GATE != G_NOT);

   logic su_any, npd_any, settled_just;
   always_comb begin
      su_any  = (in_a_i == C_SU) || (in_b_i == C_SU) || (out_req_i == C_SU);
      npd_any = (in_a_i == C_NPD) || (in_a_i == C_NPDB)
             || (DUAL && ((in_b_i == C_NPD) || (in_b_i == C_NPDB)));
      settled_just = (mode_i == M_JUST) && req_vld && !new_req && !su_any;
   end

   a_r11_su_clears: assert property (@(posedge clk) disable iff (!rst_n)
      su_any |=> (out_o == C_U) && (in_a_o == C_U) && (in_b_o == C_U));

   a_r10_npd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == M_PROP) && npd_any && !su_any
      |=> $stable(out_o) && $stable(in_a_o) && $stable(in_b_o));

   a_r6_agree_no_action: assert property (@(posedge clk) disable iff (!rst_n)
      settled_just && (in_a_i == C_CM0) && (in_a_o == C_ZERO)
      |=> $stable(out_o) && $stable(in_a_o) && $stable(in_b_o));

   a_r8_opposed_reacts: assert property (@(posedge clk) disable iff (!rst_n)
      settled_just && !pushed_q && (in_a_i == C_CM1) && (in_a_o == C_ZERO)
      |=> (in_a_o != C_ZERO) || (out_o != $past(out_o)));

   a_r2_fault_pair_masks: assert property (@(posedge clk) disable iff (!rst_n)
      DUAL && (mode_i == M_PROP) && (in_a_i == C_D) && (in_b_i == C_DB)
      && (out_req_i != C_SU)
      |=> (out_o == C_ZERO) || (out_o == C_ONE));

   a_r13_single_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !DUAL |-> (in_b_o == C_U));
endmodule

bind dcg_cell dcg_cell_chk #(.GATE(GATE)) chk_i (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
   .in_a_i(in_a_i), .in_b_i(in_b_i), .out_req_i(out_req_i),
   .in_a_o(in_a_o), .in_b_o(in_b_o), .out_o(out_o),
   .new_req(new_req), .req_vld(req_vld), .pushed_q(pushed_q)
);

// File: tb/dcg_cell_tb_top.sv
module dcg_cell_tb_top;
   import dcg_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [3:0] ia = 4'd2, ib = 4'd2, rq = 4'd2;
   logic [3:0] and_a, and_b, and_y;
   logic [3:0] nor_a, nor_b, nor_y;
   logic [3:0] not_a, not_b, not_y;
   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   dcg_cell #(.GATE(G_AND)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .in_a_i(ia), .in_b_i(ib),
      .out_req_i(rq), .in_a_o(and_a), .in_b_o(and_b), .out_o(and_y));
   dcg_cell #(.GATE(G_NOR)) nor_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .in_a_i(ia), .in_b_i(ib),
      .out_req_i(rq), .in_a_o(nor_a), .in_b_o(nor_b), .out_o(nor_y));
   dcg_cell #(.GATE(G_NOT)) not_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .in_a_i(ia), .in_b_i(ib),
      .out_req_i(rq), .in_a_o(not_a), .in_b_o(not_b), .out_o(not_y));

   task automatic chk(input string rq_tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq_tag, act, exp);
      end
   endtask

   // apply one cycle of stimulus; results are visible just after the next rising edge
   task automatic step(input logic [1:0] m, input logic [3:0] a, input logic [3:0] b,
                       input logic [3:0] r);
      @(negedge clk);
      mode = m; ia = a; ib = b; rq = r;
      @(posedge clk);
      #1;
   endtask

   task automatic clear_cell();
      step(2'd0, C_SU, C_X, C_X);
   endtask

   task automatic t_reset();
      chk("R1 and out", and_y, C_U);
      chk("R1 and a", and_a, C_U);
      chk("R1 and b", and_b, C_U);
      chk("R1 nor out", nor_y, C_U);
   endtask

   task automatic t_propagate();
      step(M_PROP, C_D, C_ONE, C_X);
      chk("R2 and(D,1)", and_y, C_D);
      chk("R13 not(D)", not_y, C_DB);
      chk("R13 not b idle", not_b, C_U);
      step(M_PROP, C_D, C_DB, C_X);
      chk("R2 and(D,DBAR)", and_y, C_ZERO);
      chk("R2 nor(D,DBAR)", nor_y, C_ZERO);
      step(M_PROP, C_D, C_ZERO, C_X);
      chk("R2 nor(D,0)", nor_y, C_DB);
      chk("R2 and(D,0)", and_y, C_ZERO);
      step(M_PROP, C_ONE, C_X, C_X);
      chk("R3 and(1,X)", and_y, C_X);
      step(M_PROP, C_U, C_ONE, C_X);
      chk("R3 and(U,1)", and_y, C_U);
      chk("R13 not(U)", not_y, C_U);
      step(M_PROP, C_ZERO, C_U, C_X);
      chk("R3 and(0,U)", and_y, C_ZERO);
   endtask

   task automatic t_npd();
      step(M_PROP, C_D, C_ONE, C_X);
      step(M_PROP, C_NPD, C_ZERO, C_X);
      chk("R10 out kept", and_y, C_D);
      chk("R10 a kept", and_a, C_D);
      step(M_PROP, C_ONE, C_NPDB, C_X);
      chk("R10 b kept", and_b, C_ONE);
   endtask

   task automatic t_justify_free();
      clear_cell();
      step(M_PROP, C_D, C_U, C_X);
      chk("R3 and(D,U)", and_y, C_U);
      step(M_JUST, C_X, C_X, C_D);
      chk("R4 out", and_y, C_D);
      chk("R4 fixed a", and_a, C_D);
      chk("R4 free b", and_b, C_ONE);
   endtask

   task automatic t_swap_flip();
      clear_cell();
      chk("R11 su out", and_y, C_U);
      chk("R11 su a", and_a, C_U);
      step(M_JUST, C_X, C_X, C_ZERO);
      chk("R5 first a", and_a, C_ZERO);
      chk("R5 first b", and_b, C_X);
      step(M_JUST, C_CM0, C_X, C_ZERO);
      chk("R6 a kept", and_a, C_ZERO);
      chk("R6 out kept", and_y, C_ZERO);
      step(M_JUST, C_CM1, C_X, C_ZERO);
      chk("R7 swapped a", and_a, C_X);
      chk("R7 swapped b", and_b, C_ZERO);
      chk("R7 out kept", and_y, C_ZERO);
      step(M_JUST, C_X, C_CM1, C_ZERO);
      chk("R9 flipped", and_y, C_ONE);
      // new requests clear the history
      step(M_JUST, C_X, C_X, C_ONE);
      chk("R12 nc a", and_a, C_ONE);
      chk("R12 nc b", and_b, C_ONE);
      step(M_JUST, C_X, C_X, C_ZERO);
      step(M_JUST, C_CM1, C_X, C_ZERO);
      chk("R12 swap again a", and_a, C_X);
      chk("R12 swap again b", and_b, C_ZERO);
   endtask

   task automatic t_insist();
      clear_cell();
      step(M_PROP, C_ONE, C_U, C_X);
      step(M_JUST, C_X, C_X, C_ZERO);
      chk("R5 fixed nc a", and_a, C_ONE);
      chk("R5 ctl b", and_b, C_ZERO);
      step(M_JUST, C_X, C_CM1, C_ZERO);
      chk("R8 insist b", and_b, C_IO0);
      chk("R8 out kept", and_y, C_ZERO);
      step(M_JUST, C_X, C_CM1, C_ZERO);
      chk("R9 flip after insist", and_y, C_ONE);
      step(M_JUST, C_X, C_CM1, C_ZERO);
      chk("R9 single flip", and_y, C_ONE);
      step(M_JUST, C_X, C_X, C_ZERO);
      step(M_PROP, C_ZERO, C_ONE, C_SU);
      chk("R11 su on req", and_y, C_U);
      chk("R11 su on req b", and_b, C_U);
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 after release", and_y, C_U);
      t_propagate();
      t_npd();
      t_justify_free();
      t_swap_flip();
      t_insist();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule